// File: doc/BRIEF.md
# Register Access SPI Transaction Master

This block turns one register read or write request from a host into one framed SPI transaction, for a security-module style SPI slave. Every transaction opens with a four-byte command header: the direction and the transfer length, then a 24-bit address. The address is the host offset plus a fixed base. On a write, the data bytes follow the header. On a read, the slave may signal that it is not ready. When it does, the master clocks single zero bytes until the slave reports ready or a poll limit runs out. The master then clocks the data bytes in. Chip select stays low for the whole transaction.

The host offers a request with `req_valid` and the block accepts it when `req_ready` is high. A request carries the direction, a register offset, a byte count and up to 32 bits of write data. The block answers with a one-cycle `rsp_done` pulse. For reads, `rsp_rdata` holds the result at the same time. Register values travel least significant byte first, and each byte goes out most significant bit first in SPI mode 0. `CLK_DIV` sets the SCLK rate: each SCLK half-period lasts `CLK_DIV` system clocks.

The controller has five states:
- IDLE: waits for a request.
- HEADER: sends the four header bytes.
- POLL: sends the wait-state polling bytes.
- DATA: moves the data bytes.
- GAP: holds chip select high before the next request.

The transitions are:
- IDLE to HEADER: a request with a legal length is accepted.
- IDLE to IDLE: an illegal length is rejected, and done and error pulse together.
- HEADER to DATA: on a write, or on a read whose fourth received header byte has bit 0 set.
- HEADER to POLL: on a read whose fourth received header byte has bit 0 clear.
- POLL to DATA: a poll byte returns bit 0 set, or the poll limit is reached.
- DATA to GAP: the last data byte completes. Chip select is released and done pulses.
- GAP to IDLE: the gap time has elapsed.

Top module: `tpm_spi_master`

## Requirements
- R1: Header byte 0 has bit 7 = 1 for a read and 0 for a write, bit 6 = 0, and bits 5:0 = byte count minus one.
- R2: Header bytes 1, 2 and 3 carry (req_offset + 0xD40000) modulo 2^24, most significant byte first.
- R3: A request whose byte count is 0 or greater than 4 produces done and error in the cycle after acceptance, and chip select never goes low.
- R4: On a read whose fourth received header byte has bit 0 = 1, the data bytes follow at once, for a total of 4 + count bytes.
- R5: On a read whose fourth received header byte has bit 0 = 0, single zero bytes are clocked until one returns bit 0 = 1. That ready byte is itself the last poll, and the data bytes follow it.
- R6: After 50 polls with bit 0 = 0, the data phase starts anyway and the timeout status bit is set. A ready bit on the 50th poll does not set the timeout bit. The bit stays set across later transactions until reset.
- R7: Read data bytes are assembled least significant byte first into rsp_rdata, with unused upper bytes zero. MOSI carries zero bytes in the poll and data phases of a read.
- R8: On a write, the header is followed directly by count bytes of req_wdata, least significant byte first, for 4 + count bytes. There is no polling, whatever the slave returns.
- R9: SPI mode 0 applies. SCLK idles low and is low whenever chip select is high. MISO is sampled on the rising SCLK edge, MOSI changes on the falling edge, and each byte goes out most significant bit first.
- R10: Chip select has exactly one low period per valid transaction. Between transactions it stays high for at least 2*CLK_DIV clocks. req_ready is low from acceptance until after that gap.
- R11: rsp_done is a one-cycle pulse, and rsp_err is only ever high together with rsp_done.
- R12: During and after reset, spi_cs_n = 1, spi_sclk = 0, req_ready = 1, rsp_done = 0 and timeout_sticky = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_offset | input | 24 | Register offset added to the fixed base |
| req_len | input | 3 | Byte count, legal 1 to 4 |
| req_wdata | input | 32 | Write value, least significant byte sent first |
| rsp_done | output | 1 | Transaction complete pulse |
| rsp_err | output | 1 | Request rejected, valid with rsp_done |
| rsp_rdata | output | 32 | Read value, valid from rsp_done until the next read |
| timeout_sticky | output | 1 | Poll limit was reached, cleared only by reset |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in |

## Verification
Two events can fall on the same byte: the poll counter reaching its limit, and the slave raising its ready bit on that same poll. The bench provokes this with a slave model that becomes ready on exactly the 50th poll. It compares that case with one where the slave becomes ready on the 51st poll. In both cases the bench counts the bytes under chip select, which must be 54 + count. In the first case timeout_sticky must stay clear; in the second it must be set, and the read data must still arrive intact.

// File: rtl/tpm_spi_pkg.sv
package tpm_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_POLL,
        ST_DATA,
        ST_GAP
    } tsm_state_e;

    // Header lead byte: direction in bit 7, bit 6 zero, count-1 in bits 5:0
    function automatic logic [7:0] lead_byte(input logic rd, input logic [5:0] cnt_m1);
        return {rd, 1'b0, cnt_m1};
    endfunction

endpackage

// File: rtl/tsm_sclk_div.sv
module tsm_sclk_div #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = $clog2(CLK_DIV + 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = en && (cnt_q == CNT_W'(CLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tsm_byte_shifter.sv
module tsm_byte_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    logic [7:0] sh_q;
    logic [2:0] bit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            sh_q    <= '0;
            bit_q   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                sh_q  <= tx_byte;
                mosi  <= tx_byte[7];
                sclk  <= 1'b0;
                bit_q <= '0;
            end else if (busy && tick) begin
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                        mosi  <= sh_q[6];
                    end
                end
            end
        end
    end

    // R9: a new byte is only launched while the shifter is idle
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R9: a byte completes on a falling SCLK edge
    done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sclk);

endmodule

// File: rtl/tsm_hdr_build.sv
module tsm_hdr_build #(
    parameter int          ADDR_W    = 24,
    parameter int          LEN_W     = 3,
    parameter logic [23:0] BASE_ADDR = 24'hD40000
) (
    input  logic              rd,
    input  logic [LEN_W-1:0]  len,
    input  logic [ADDR_W-1:0] offset,
    output logic [3:0][7:0]   hdr
);
    import tpm_spi_pkg::*;

    logic [23:0] addr;
    logic [5:0]  cnt_m1;

    always_comb begin
        addr   = 24'(offset) + BASE_ADDR;
        cnt_m1 = 6'(len) - 6'd1;
        hdr[0] = lead_byte(rd, cnt_m1);
        hdr[1] = addr[23:16];
        hdr[2] = addr[15:8];
        hdr[3] = addr[7:0];
    end

endmodule

// File: rtl/tpm_spi_master.sv
module tpm_spi_master #(
    parameter int          CLK_DIV   = 2,
    parameter int          MAX_WAIT  = 50,
    parameter int          MAX_BYTES = 4,
    parameter int          ADDR_W    = 24,
    parameter logic [23:0] BASE_ADDR = 24'hD40000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_read,
    input  logic [23:0] req_offset,
    input  logic [2:0]  req_len,
    input  logic [31:0] req_wdata,
    output logic        rsp_done,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata,
    output logic        timeout_sticky,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    import tpm_spi_pkg::*;

    localparam int DATA_W  = 8 * MAX_BYTES;
    localparam int LEN_W   = $clog2(MAX_BYTES) + 1;
    localparam int IDX_W   = $clog2(MAX_BYTES);
    localparam int PC_W    = $clog2(MAX_WAIT + 1);
    localparam int GAP_CYC = 2 * CLK_DIV;
    localparam int GC_W    = $clog2(GAP_CYC + 1);

    tsm_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [PC_W-1:0]   poll_q;
    logic [GC_W-1:0]   gap_q;
    logic              rd_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] wdata_q;
    logic [3:0][7:0]   hdr_q;
    logic [3:0][7:0]   hdr_now;

    logic              xfer_start, xfer_busy, xfer_done, tick;
    logic [7:0]        xfer_tx, xfer_rx;

    logic              accept, len_ok, last_byte;
    logic [IDX_W-1:0]  idx_nx;
    logic [7:0]        data_first, data_next;

    // ---------------- sub-blocks ----------------
    tsm_hdr_build #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .BASE_ADDR(BASE_ADDR)
    ) hdr_i (
        .rd    (req_read),
        .len   (LEN_W'(req_len)),
        .offset(ADDR_W'(req_offset)),
        .hdr   (hdr_now)
    );

    tsm_sclk_div #(.CLK_DIV(CLK_DIV)) div_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (xfer_busy),
        .tick (tick)
    );

    tsm_byte_shifter shf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .start  (xfer_start),
        .tx_byte(xfer_tx),
        .miso   (spi_miso),
        .busy   (xfer_busy),
        .done   (xfer_done),
        .rx_byte(xfer_rx),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi)
    );

    // ---------------- decode ----------------
    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign len_ok     = (req_len != 3'd0) && (LEN_W'(req_len) <= LEN_W'(MAX_BYTES));
    assign last_byte  = (LEN_W'(idx_q) == (len_q - 1'b1));
    assign idx_nx     = idx_q + 1'b1;
    assign data_first = rd_q ? 8'h00 : wdata_q[7:0];
    assign data_next  = rd_q ? 8'h00 : wdata_q[{idx_nx, 3'b000} +: 8];

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && len_ok) state_d = ST_HDR;
            ST_HDR: begin
                if (xfer_done && idx_q == IDX_W'(3)) begin
                    state_d = (rd_q && !xfer_rx[0]) ? ST_POLL : ST_DATA;
                end
            end
            ST_POLL: begin
                if (xfer_done && (xfer_rx[0] || poll_q == PC_W'(MAX_WAIT))) begin
                    state_d = ST_DATA;
                end
            end
            ST_DATA: if (xfer_done && last_byte) state_d = ST_GAP;
            ST_GAP:  if (gap_q == GC_W'(GAP_CYC - 1)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_cs_n       <= 1'b1;
            xfer_start     <= 1'b0;
            xfer_tx        <= '0;
            rsp_done       <= 1'b0;
            rsp_err        <= 1'b0;
            rsp_rdata      <= '0;
            timeout_sticky <= 1'b0;
            idx_q          <= '0;
            poll_q         <= '0;
            gap_q          <= '0;
            rd_q           <= 1'b0;
            len_q          <= '0;
            wdata_q        <= '0;
            hdr_q          <= '0;
        end else begin
            xfer_start <= 1'b0;
            rsp_done   <= 1'b0;
            rsp_err    <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (!len_ok) begin
                            rsp_done <= 1'b1;
                            rsp_err  <= 1'b1;
                        end else begin
                            rd_q       <= req_read;
                            len_q      <= LEN_W'(req_len);
                            wdata_q    <= DATA_W'(req_wdata);
                            hdr_q      <= hdr_now;
                            idx_q      <= '0;
                            poll_q     <= '0;
                            spi_cs_n   <= 1'b0;
                            xfer_start <= 1'b1;
                            xfer_tx    <= hdr_now[0];
                            if (req_read) rsp_rdata <= '0;
                        end
                    end
                end
                ST_HDR: begin
                    if (xfer_done) begin
                        xfer_start <= 1'b1;
                        if (idx_q == IDX_W'(3)) begin
                            idx_q <= '0;
                            if (rd_q && !xfer_rx[0]) begin
                                poll_q  <= PC_W'(1);
                                xfer_tx <= 8'h00;
                            end else begin
                                xfer_tx <= data_first;
                            end
                        end else begin
                            idx_q   <= idx_nx;
                            xfer_tx <= hdr_q[idx_nx[1:0]];
                        end
                    end
                end
                ST_POLL: begin
                    if (xfer_done) begin
                        xfer_start <= 1'b1;
                        if (xfer_rx[0] || poll_q == PC_W'(MAX_WAIT)) begin
                            if (!xfer_rx[0]) timeout_sticky <= 1'b1;
                            idx_q   <= '0;
                            xfer_tx <= data_first;
                        end else begin
                            poll_q  <= poll_q + 1'b1;
                            xfer_tx <= 8'h00;
                        end
                    end
                end
                ST_DATA: begin
                    if (xfer_done) begin
                        if (rd_q) rsp_rdata[{idx_q, 3'b000} +: 8] <= xfer_rx;
                        if (last_byte) begin
                            spi_cs_n <= 1'b1;
                            rsp_done <= 1'b1;
                            gap_q    <= '0;
                        end else begin
                            idx_q      <= idx_nx;
                            xfer_start <= 1'b1;
                            xfer_tx    <= data_next;
                        end
                    end
                end
                ST_GAP: begin
                    gap_q <= gap_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    // R10
    ready_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n);

    // R10
    gap_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> spi_cs_n);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R11
    err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    // R9
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R6
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL) |-> (poll_q != '0 && poll_q <= PC_W'(MAX_WAIT)));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(timeout_sticky));

    // R3
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !len_ok) |=> (spi_cs_n && rsp_err));

endmodule

// File: tb/tpm_spi_master_tb_top.sv
module tpm_spi_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 2;
    localparam int MAX_WAIT   = 50;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_read;
    logic [23:0] req_offset;
    logic [2:0]  req_len;
    logic [31:0] req_wdata;
    logic        rsp_done, rsp_err;
    logic [31:0] rsp_rdata;
    logic        timeout_sticky;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpm_spi_master #(.CLK_DIV(CLK_DIV), .MAX_WAIT(MAX_WAIT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_offset(req_offset), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .timeout_sticky(timeout_sticky),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    logic        m_rd;
    int          m_wait, m_polls;
    logic [31:0] m_rdata;
    int          byte_idx, bit_pos, nbits, cs_falls;
    logic [7:0]  mosi_sh;
    logic [7:0]  mosi_log [0:63];

    function automatic logic [7:0] resp_byte(input int idx);
        int k;
        if (idx < 3) return 8'h5A;
        if (idx == 3) return {7'b1010101, (m_wait == 0)};
        k = idx - 3;
        if (k <= m_polls) return {7'b0110011, (k >= m_wait)};
        k = idx - 4 - m_polls;
        if (k < 4) return m_rdata[8*k +: 8];
        return 8'h00;
    endfunction

    function automatic logic resp_bit(input int idx, input int pos);
        logic [7:0] b;
        b = resp_byte(idx);
        return b[7-pos];
    endfunction

    always @(negedge spi_cs_n) begin
        byte_idx = 0; bit_pos = 0; nbits = 0; cs_falls++;
        spi_miso = resp_bit(0, 0);
    end

    // R9: slave changes MISO on falling SCLK, captures MOSI on rising SCLK
    always @(negedge spi_sclk) if (!spi_cs_n) begin
        bit_pos++;
        if (bit_pos == 8) begin bit_pos = 0; byte_idx++; end
        spi_miso = resp_bit(byte_idx, bit_pos);
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        mosi_sh = {mosi_sh[6:0], spi_mosi};
        nbits++;
        if (nbits % 8 == 0 && nbits / 8 <= 64) mosi_log[nbits/8 - 1] = mosi_sh;
    end

    // R10: chip-select high time between transactions
    logic cs_prev = 1'b1;
    int   gap_run = 0;
    bit   seen_rise = 0;
    always @(negedge clk) begin
        if (rst_n && cs_prev && !spi_cs_n && seen_rise)
            chk(gap_run >= 2*CLK_DIV, "R10", "cs high gap", gap_run, 2*CLK_DIV);
        if (!cs_prev && spi_cs_n) begin seen_rise = 1; gap_run = 0; end
        if (spi_cs_n) gap_run++;
        cs_prev = spi_cs_n;
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++; tests++;
            $display("FAIL watchdog: actual %0d expected < 190000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    logic tout_exp;

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0; req_read = 1'b0; req_offset = '0; req_len = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        // R12
        chk(spi_cs_n == 1'b1, "R12", "cs_n in reset", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R12", "sclk in reset", spi_sclk, 0);
        chk(req_ready == 1'b1, "R12", "ready in reset", req_ready, 1);
        chk(rsp_done == 1'b0, "R12", "done in reset", rsp_done, 0);
        chk(timeout_sticky == 1'b0, "R12", "timeout in reset", timeout_sticky, 0);
        rst_n = 1'b1;
        tout_exp = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_txn(input bit rd, input logic [23:0] off, input int len,
                           input logic [31:0] wdata, input logic [31:0] rdat, input int wt);
        int          falls0, wd, nb, p;
        bit          bad;
        logic [23:0] addr;
        logic [7:0]  h0;
        logic [31:0] exp_rd;
        bad = (len == 0) || (len > 4);
        m_rd = rd; m_wait = wt; m_rdata = rdat;
        p = (!rd || wt == 0) ? 0 : ((wt > MAX_WAIT) ? MAX_WAIT : wt);
        m_polls = p;
        if (rd && !bad && wt > MAX_WAIT) tout_exp = 1'b1;
        falls0 = cs_falls;
        req_valid = 1'b1; req_read = rd; req_offset = off; req_len = 3'(len); req_wdata = wdata;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R10: no new request accepted while busy
        if (!bad) chk(req_ready == 1'b0, "R10", "ready after accept", req_ready, 0);
        wd = 0;
        while (!rsp_done && wd < 20000) begin @(negedge clk); wd++; end
        chk(rsp_done == 1'b1, "R11", "done seen", rsp_done, 1);
        if (bad) begin
            // R3
            chk(rsp_err == 1'b1, "R3", "error on bad length", rsp_err, 1);
            chk(cs_falls == falls0, "R3", "no chip select", cs_falls - falls0, 0);
            chk(wd == 0, "R3", "done latency", wd, 0);
        end else begin
            chk(rsp_err == 1'b0, "R11", "no error", rsp_err, 0);
            chk(cs_falls - falls0 == 1, "R10", "one cs low period", cs_falls - falls0, 1);
            chk(spi_sclk == 1'b0 && spi_cs_n == 1'b1, "R9", "sclk low after cs", spi_sclk, 0);
            nb = rd ? (4 + p + len) : (4 + len);
            chk(nbits == nb * 8, rd ? (wt == 0 ? "R4" : "R5") : "R8", "bit count", nbits, nb * 8);
            h0 = {rd, 1'b0, 6'(len - 1)};
            chk(mosi_log[0] == h0, "R1", "header byte 0", mosi_log[0], h0);
            addr = off + 24'hD40000;
            chk({mosi_log[1], mosi_log[2], mosi_log[3]} == addr, "R2", "address",
                {mosi_log[1], mosi_log[2], mosi_log[3]}, addr);
            if (rd) begin
                for (int i = 4; i < nb; i++)
                    chk(mosi_log[i] == 8'h00, "R7", "zero mosi on read", mosi_log[i], 0);
                exp_rd = 32'h0;
                for (int j = 0; j < len; j++) exp_rd[8*j +: 8] = rdat[8*j +: 8];
                chk(rsp_rdata == exp_rd, "R7", "read data", rsp_rdata, exp_rd);
            end else begin
                for (int j = 0; j < len; j++)
                    chk(mosi_log[4+j] == wdata[8*j +: 8], "R8", "write byte", mosi_log[4+j], wdata[8*j +: 8]);
            end
        end
        chk(timeout_sticky == tout_exp, "R6", "timeout bit", timeout_sticky, tout_exp);
        @(negedge clk);
        chk(rsp_done == 1'b0, "R11", "done one cycle", rsp_done, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset();
        // directed corners
        run_txn(0, 24'h000024, 4, 32'hA1B2C3D4, 32'h0, 0);    // R8
        run_txn(0, 24'h000018, 1, 32'h0000007E, 32'h0, 3);    // R8 no poll on write
        run_txn(1, 24'h000F00, 4, 32'h0, 32'h11223344, 0);    // R4 R7
        run_txn(1, 24'h000030, 2, 32'h0, 32'hDEADBEEF, 3);    // R5
        run_txn(1, 24'h2C0010, 1, 32'h0, 32'h000000C5, 1);    // R2 wrap, R5
        run_txn(1, 24'h000000, 0, 32'h0, 32'h0, 0);           // R3
        run_txn(0, 24'h000000, 5, 32'h0, 32'h0, 0);           // R3
        run_txn(1, 24'h000004, 7, 32'h0, 32'h0, 0);           // R3
        run_txn(1, 24'h000008, 3, 32'h0, 32'h00ABCDEF, 50);   // R6 ready on last poll
        run_txn(1, 24'h00000C, 4, 32'h0, 32'hCAFEF00D, 51);   // R6 limit reached
        run_txn(0, 24'h000010, 2, 32'h00005A5A, 32'h0, 0);    // R6 sticky persists
        run_txn(1, 24'h000014, 1, 32'h0, 32'h00000099, 0);    // R6 sticky persists
        do_reset();                                           // R12 clears sticky
        // random mix
        for (int n = 0; n < 40; n++) begin
            bit          rd;
            int          len, wt;
            logic [23:0] off;
            rd  = 1'($urandom % 2);
            len = 1 + int'($urandom % 4);
            off = 24'($urandom);
            wt  = ($urandom % 3 == 0) ? int'($urandom % 6) : 0;
            run_txn(rd, off, len, $urandom, $urandom, wt);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule